// File: doc/BRIEF.md
# 8-bit Waveform Timer with CTC and Fast PWM

This block is an 8-bit up-counter driven by a programmable clock divider. It drives one waveform output. In clear-on-compare mode the count restarts after it reaches compare value A, and the output toggles on each match. This gives a square wave whose frequency is set by the compare value and the divider. In the two fast PWM modes the counter forms a single-slope sawtooth. The sawtooth ends at either the full-scale value or compare value A, and the output is set or cleared at the sawtooth's restart and at a compare match.

Software programs the block through a narrow register-write port. Three sticky flags record counter turnover and the two compare matches. The host clears a flag by writing a one to its bit. A direction bit combines with the output rule to form an output enable, which the pad logic uses to decide whether the waveform reaches the pin.

Top module: `wave_timer8`

## Requirements
- R1: While reset is low, `count_o` is 0, `flags_o` is 0, `wave_out` is 0 and `wave_oe` is 0.
- R2: The divider code is written at address 1, bits [2:0]. Codes 1 to 7 select one counter tick every 1, 8, 32, 64, 128, 256 or 1024 clocks. Code 0 halts the counter. Writing the code restarts the division. The count changes only on a tick.
- R3: The mode code is written at address 0, bits [2:0]. The output rule is written at bits [4:3] and the direction bit at bit [7]. Mode code 2 is clear-on-compare: on the tick where the count equals compare A (address 2), the count returns to 0. With output rule 1, the output inverts on each such match, so one level lasts (A+1)·N clocks.
- R4: In mode 2, if compare A is written below the current count, the counter runs on to 0xFF, wraps to 0, and matches A only after that wrap.
- R5: Mode code 3 is fast PWM with a top value of 0xFF. Mode code 7 is fast PWM with compare A as the top value. The count climbs to the top value and returns to 0 on the next tick.
- R6: In fast PWM, the duty source C is compare A in mode 3 and compare B (address 3) in mode 7. Output rule 2 sets the output at the restart and clears it on a match with C, so the output is high for (C+1) of every (top+1) ticks. Output rule 3 gives the complement.
- R7: In fast PWM, a compare write goes to a shadow register and becomes active only at the tick where the count turns over from top to 0. In the other modes the written value is active from the clock after the write.
- R8: Flag bit 0 (overflow) sets on the turnover tick in fast PWM. In the other modes it sets only on the 0xFF-to-0 wrap.
- R9: Flag bits 1 and 2 set on the tick where the count equals the active compare A or B. Flags stay set until a one is written to the same bit at address 4. If a flag sets and clears in the same clock, it stays set.
- R10: `wave_oe` is high exactly when the direction bit is 1 and the output rule is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| wave_out | output | 1 | Waveform level |
| wave_oe | output | 1 | Output enable for the pin driver |
| flags_o | output | 3 | Sticky flags: [0] overflow, [1] match A, [2] match B |
| count_o | output | 8 | Current counter value |

## Verification
A register write is captured on the rising edge where it is presented. The output enable and the mode follow from that edge. The active compare value follows one edge later in the non-PWM modes, or at the next turnover in fast PWM. The count, the waveform level and the flags each change on the edge that closes the tick causing them. The bench drives inputs and samples outputs on the falling edge, so every check reads a value that has settled since the last rising edge. Duty and half-period checks count falling edges over a whole period after a settling delay, so their results do not depend on the phase at which the period began.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int NCMP  = 2;
  localparam int NFLAG = 3;

  localparam logic [2:0] MD_FREE     = 3'd0;
  localparam logic [2:0] MD_CTC      = 3'd2;
  localparam logic [2:0] MD_PWM_FULL = 3'd3;
  localparam logic [2:0] MD_PWM_VAR  = 3'd7;

  localparam int RA_CTRL = 0;
  localparam int RA_PSC  = 1;
  localparam int RA_CMP0 = 2;
  localparam int RA_FLAG = 4;

  typedef enum logic [1:0] {
    COM_OFF    = 2'd0,
    COM_TOGGLE = 2'd1,
    COM_CLR    = 2'd2,
    COM_SET    = 2'd3
  } com_e;

  function automatic logic is_pwm(input logic [2:0] m);
    return (m == MD_PWM_FULL) || (m == MD_PWM_VAR);
  endfunction

  function automatic logic top_from_a(input logic [2:0] m);
    return (m == MD_CTC) || (m == MD_PWM_VAR);
  endfunction

  function automatic int unsigned div_of(input logic [2:0] s);
    case (s)
      3'd1: return 1;
      3'd2: return 8;
      3'd3: return 32;
      3'd4: return 64;
      3'd5: return 128;
      3'd6: return 256;
      3'd7: return 1024;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CW = 8,
  parameter int AW = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [CW-1:0]             wr_data,
  output logic [2:0]                mode,
  output com_e                      com,
  output logic                      dir,
  output logic [2:0]                psel,
  output logic                      psel_wr,
  output logic [NCMP-1:0][CW-1:0]   shadow,
  output logic [NFLAG-1:0]          flag_clr
);

  logic sel_ctrl;
  logic sel_flag;
  logic [NCMP-1:0] sel_cmp;

  assign sel_ctrl = wr_en && (wr_addr == AW'(RA_CTRL));
  assign psel_wr  = wr_en && (wr_addr == AW'(RA_PSC));
  assign sel_flag = wr_en && (wr_addr == AW'(RA_FLAG));
  assign flag_clr = sel_flag ? wr_data[NFLAG-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= MD_FREE;
      com  <= COM_OFF;
      dir  <= 1'b0;
    end else if (sel_ctrl) begin
      mode <= wr_data[2:0];
      com  <= com_e'(wr_data[4:3]);
      dir  <= wr_data[CW-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       psel <= 3'd0;
    else if (psel_wr) psel <= wr_data[2:0];
  end

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    assign sel_cmp[g] = wr_en && (wr_addr == AW'(RA_CMP0 + g));
    always_ff @(posedge clk) begin
      if (!rst_n)          shadow[g] <= '0;
      else if (sel_cmp[g]) shadow[g] <= wr_data;
    end
  end

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int PSW = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       sel_wr,
  output logic       tick
);

  logic [PSW-1:0] pcnt;
  logic [PSW-1:0] lim;
  logic           run;

  assign run  = (sel != 3'd0);
  assign lim  = run ? PSW'(div_of(sel) - 1) : '0;
  assign tick = run && (pcnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n)                     pcnt <= '0;
    else if (sel_wr || tick || !run) pcnt <= '0;
    else                            pcnt <= pcnt + 1'b1;
  end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic [2:0]              mode,
  input  logic                    pwm,
  input  logic [NCMP-1:0][CW-1:0] shadow,
  output logic [CW-1:0]           cnt,
  output logic [NCMP-1:0][CW-1:0] act,
  output logic [CW-1:0]           top,
  output logic                    turn,
  output logic                    ovf_evt,
  output logic [NCMP-1:0]         hit
);

  localparam logic [CW-1:0] MAXV = '1;

  logic at_top;
  logic at_max;

  assign top     = top_from_a(mode) ? act[0] : MAXV;
  assign at_top  = (cnt == top);
  assign at_max  = (cnt == MAXV);
  assign turn    = tick && at_top;
  assign ovf_evt = tick && (pwm ? at_top : at_max);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= at_top ? '0 : cnt + 1'b1;
  end

  for (genvar g = 0; g < NCMP; g++) begin : g_ch
    assign hit[g] = tick && (cnt == act[g]);
    always_ff @(posedge clk) begin
      if (!rst_n)          act[g] <= '0;
      else if (!pwm)       act[g] <= shadow[g];
      else if (turn)       act[g] <= shadow[g];
    end
  end

endmodule

// File: rtl/tmr_wave.sv
module tmr_wave
  import tmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pwm,
  input  com_e com,
  input  logic hit,
  input  logic turn,
  output logic level
);

  logic nxt;
  logic restart;

  assign restart = pwm && turn;

  always_comb begin
    nxt = level;
    case (com)
      COM_TOGGLE: if (hit) nxt = ~level;
      COM_CLR: begin
        if (restart)  nxt = 1'b1;
        else if (hit) nxt = 1'b0;
      end
      COM_SET: begin
        if (restart)  nxt = 1'b0;
        else if (hit) nxt = 1'b1;
      end
      default: nxt = level;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) level <= 1'b0;
    else        level <= nxt;
  end

endmodule

// File: rtl/wave_timer8.sv
module wave_timer8
  import tmr_pkg::*;
#(
  parameter int CW  = 8,
  parameter int PSW = 10,
  parameter int AW  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [CW-1:0]    wr_data,
  output logic             wave_out,
  output logic             wave_oe,
  output logic [NFLAG-1:0] flags_o,
  output logic [CW-1:0]    count_o
);

  logic [2:0]              mode;
  com_e                    com;
  logic                    dir;
  logic [2:0]              psel;
  logic                    psel_wr;
  logic [NCMP-1:0][CW-1:0] shadow;
  logic [NCMP-1:0][CW-1:0] act;
  logic [NFLAG-1:0]        flag_clr;
  logic [NFLAG-1:0]        flag_set;
  logic [NFLAG-1:0]        flag_q;
  logic                    tick;
  logic                    pwm;
  logic [CW-1:0]           cnt;
  logic [CW-1:0]           top;
  logic                    turn;
  logic                    ovf_evt;
  logic [NCMP-1:0]         hit;
  logic                    duty_hit;
  logic                    level;

  assign pwm = is_pwm(mode);

  tmr_regs #(.CW(CW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode(mode), .com(com), .dir(dir), .psel(psel), .psel_wr(psel_wr),
    .shadow(shadow), .flag_clr(flag_clr)
  );

  tmr_prescaler #(.PSW(PSW)) u_psc (
    .clk(clk), .rst_n(rst_n), .sel(psel), .sel_wr(psel_wr), .tick(tick)
  );

  tmr_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .pwm(pwm),
    .shadow(shadow), .cnt(cnt), .act(act), .top(top), .turn(turn),
    .ovf_evt(ovf_evt), .hit(hit)
  );

  assign duty_hit = (mode == MD_PWM_VAR) ? hit[1] : hit[0];

  tmr_wave u_wave (
    .clk(clk), .rst_n(rst_n), .pwm(pwm), .com(com), .hit(duty_hit),
    .turn(turn), .level(level)
  );

  assign flag_set = {hit, ovf_evt};

  for (genvar f = 0; f < NFLAG; f++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)           flag_q[f] <= 1'b0;
      else if (flag_set[f]) flag_q[f] <= 1'b1;
      else if (flag_clr[f]) flag_q[f] <= 1'b0;
    end
  end

  assign flags_o  = flag_q;
  assign count_o  = cnt;
  assign wave_out = level;
  assign wave_oe  = dir && (com != COM_OFF);

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
#(
  parameter int CW = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    tick,
  input logic                    pwm,
  input logic [CW-1:0]           cnt,
  input logic                    turn,
  input logic                    ovf_evt,
  input logic [NCMP-1:0]         hit,
  input logic [NCMP-1:0][CW-1:0] act,
  input logic [NFLAG-1:0]        flags,
  input logic [NFLAG-1:0]        flag_clr
);

  // R2
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  // R5
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    turn |=> (cnt == '0));

  // R8
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flags[0]);

  // R9
  hit_a_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |=> flags[1]);

  // R9
  hit_b_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit[1] |=> flags[2]);

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !flag_clr[0]) |=> flags[0]);

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !turn) |=> $stable(act[0]));

endmodule

bind wave_timer8 tmr_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .pwm(pwm), .cnt(cnt), .turn(turn),
  .ovf_evt(ovf_evt), .hit(hit), .act(act), .flags(flag_q), .flag_clr(flag_clr)
);

// File: tb/sim_wave_timer8.sv
module sim_wave_timer8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       wave_out;
  logic       wave_oe;
  logic [2:0] flags_o;
  logic [7:0] count_o;

  int total = 0;
  int fails = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  wave_timer8 u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wave_out(wave_out), .wave_oe(wave_oe), .flags_o(flags_o), .count_o(count_o)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic [1:0]  com;
    logic [2:0]  psel;
    logic [7:0]  a;
    logic [7:0]  b;
    logic [15:0] win;
    logic [15:0] hi;
  } vec_t;

  // duty vectors: high clocks expected over one full period window
  localparam vec_t VECS [8] = '{
    '{3'd3, 2'd2, 3'd1, 8'd63,  8'd0,  16'd256,  16'd64},
    '{3'd3, 2'd2, 3'd1, 8'd0,   8'd0,  16'd256,  16'd1},
    '{3'd3, 2'd2, 3'd1, 8'd255, 8'd0,  16'd256,  16'd256},
    '{3'd3, 2'd3, 3'd1, 8'd63,  8'd0,  16'd256,  16'd192},
    '{3'd7, 2'd2, 3'd1, 8'd99,  8'd24, 16'd100,  16'd25},
    '{3'd7, 2'd2, 3'd1, 8'd9,   8'd9,  16'd10,   16'd10},
    '{3'd7, 2'd3, 3'd1, 8'd19,  8'd4,  16'd20,   16'd15},
    '{3'd3, 2'd2, 3'd2, 8'd127, 8'd0,  16'd2048, 16'd1024}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ctl(input logic d, input logic [1:0] c, input logic [2:0] m);
    return {d, 2'b00, c, m};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_addr = a;
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wait_cnt(input logic [7:0] v);
    int g = 0;
    @(negedge clk);
    while (count_o != v && g < 20000) begin
      @(negedge clk);
      g++;
    end
  endtask

  task automatic half_period(output int n);
    logic prev;
    int g = 0;
    prev = wave_out;
    while (wave_out == prev && g < 3000) begin
      @(negedge clk);
      g++;
    end
    prev = wave_out;
    n = 0;
    while (wave_out == prev && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic max_until_zero(output int mx);
    mx = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (count_o == 8'd0) break;
      if (int'(count_o) > mx) mx = int'(count_o);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      fails++;
      total++;
      $display("FAIL watchdog R1 actual=%0d expected=<%0d", cyc, 190000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int n;
    int hi;
    int mx;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 count", int'(count_o), 0);
    chk("R1 flags", int'(flags_o), 0);
    chk("R1 wave", int'(wave_out), 0);
    chk("R1 oe", int'(wave_oe), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 R6 R2: table walk
    foreach (VECS[k]) begin
      wr(3'd0, ctl(1'b1, VECS[k].com, VECS[k].mode));
      wr(3'd2, VECS[k].a);
      wr(3'd3, VECS[k].b);
      wr(3'd1, {5'd0, VECS[k].psel});
      repeat (600 + 2 * int'(VECS[k].win)) @(negedge clk);
      hi = 0;
      for (int i = 0; i < int'(VECS[k].win); i++) begin
        if (wave_out) hi++;
        @(negedge clk);
      end
      chk($sformatf("R5 R6 duty vector %0d", k), hi, int'(VECS[k].hi));
    end

    // R9: match and overflow flags in fast PWM, A=63 B=30
    wr(3'd0, ctl(1'b1, 2'd2, 3'd3));
    wr(3'd1, 8'd1);
    wr(3'd2, 8'd63);
    wr(3'd3, 8'd30);
    wait_cnt(8'd0);
    wait_cnt(8'd0);
    wait_cnt(8'd5);
    wr(3'd4, 8'h07);
    chk("R9 cleared", int'(flags_o), 0);
    wait_cnt(8'd40);
    chk("R9 match B only", int'(flags_o), 4);
    wait_cnt(8'd70);
    chk("R9 match A and B", int'(flags_o), 6);
    wait_cnt(8'd0);
    chk("R8 turnover sets overflow", int'(flags_o), 7);

    // R2 halt, R9 write-one clear
    wr(3'd1, 8'd0);
    wr(3'd4, 8'h07);
    n = int'(count_o);
    repeat (20) @(negedge clk);
    chk("R9 clear holds", int'(flags_o), 0);
    chk("R2 halted count", int'(count_o), n);

    // R7: shadowed compare in fast PWM
    wr(3'd1, 8'd1);
    wait_cnt(8'd10);
    wr(3'd2, 8'd200);
    wait_cnt(8'd100);
    chk("R7 old compare still active", int'(wave_out), 0);
    wait_cnt(8'd100);
    chk("R7 new compare after turnover", int'(wave_out), 1);

    // R3 R2: clear-on-compare toggle periods
    wr(3'd0, ctl(1'b1, 2'd1, 3'd2));
    wr(3'd2, 8'd4);
    half_period(n);
    chk("R3 half period A=4 N=1", n, 5);
    wr(3'd2, 8'd0);
    half_period(n);
    chk("R3 half period A=0 N=1", n, 1);
    wr(3'd1, 8'd7);
    half_period(n);
    chk("R2 half period A=0 N=1024", n, 1024);
    wr(3'd1, 8'd2);
    wr(3'd2, 8'd4);
    half_period(n);
    chk("R2 R3 half period A=4 N=8", n, 40);

    // R4 R8: compare written below the count
    wr(3'd1, 8'd1);
    wr(3'd2, 8'd200);
    wait_cnt(8'd50);
    wr(3'd4, 8'h07);
    wait_cnt(8'd150);
    chk("R8 no overflow below 0xFF", int'(flags_o[0]), 0);
    wr(3'd2, 8'd100);
    max_until_zero(mx);
    chk("R4 runs to 0xFF", mx, 255);
    chk("R8 overflow on wrap", int'(flags_o[0]), 1);
    max_until_zero(mx);
    chk("R4 new compare after wrap", mx, 100);

    // R10: output enable
    wr(3'd0, ctl(1'b0, 2'd2, 3'd3));
    chk("R10 dir low", int'(wave_oe), 0);
    wr(3'd0, ctl(1'b1, 2'd0, 3'd3));
    chk("R10 rule off", int'(wave_oe), 0);
    wr(3'd0, ctl(1'b1, 2'd2, 3'd3));
    chk("R10 enabled", int'(wave_oe), 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule